// File: doc/BRIEF.md
# Descriptor ring ownership engine

The engine walks a circular ring of four-word buffer descriptors that sit in a memory shared by the host and the controller. The ring lives at a programmable 32-bit base and holds a power-of-two number of entries. At the current index the engine reads the word that carries the ownership flag. When the flag says the controller owns the entry, the engine reads the buffer address and offers the address and the byte count to a downstream consumer over a valid/ready handshake. When the consumer signals completion, the engine writes a status word into the descriptor and then, in a separate memory cycle, hands the entry back to the host by clearing the flag. It then moves on to the next index and wraps after the last entry.

Ownership is a single-writer handshake. If the entry at the current index belongs to the host, the engine reads nothing else from it and touches no later entry. It waits at that index until a poll pulse arrives or an internal interval timer expires, and then reads the flag again. A chip uses one instance for each ring direction, and each instance has its own base address and its own length.

Descriptor layout, as byte offsets from the descriptor address base + 16 * index:
- offset 0: buffer address.
- offset 4: ownership flag in bit 31, where 1 means the controller owns the entry. The byte count is in bits 15:0.
- offset 8: status.
- offset 12: unused.

Top module: `ring_own_engine`

## Requirements
- R1: After reset the engine issues no memory request, holds buf_valid and err low, and is at index 0. While nothing wakes it, it stays quiet.
- R2: While the engine waits, a poll pulse wakes it, and so does the passing of POLL_CYCLES cycles without one. On waking, it issues a read (mem_req=1, mem_we=0) of the ownership word at base + 16*index + 4.
- R3: If bit 31 of the ownership word is 0, the engine does not read the rest of that descriptor, writes nothing, reads no other entry, offers nothing, and waits again at the same index.
- R4: If bit 31 is 1, the engine reads offset 0 and then asserts buf_valid with buf_addr = word 0 and buf_len = ownership word bits 15:0. These values stay stable until buf_ready is seen high.
- R5: On a done pulse after the handshake, the engine writes {done_stat, done_count} to offset 8. In the next cycle it writes the ownership word back with bit 31 cleared and bits 30:0 unchanged to offset 4. These are the only writes the engine makes, and no write ever sets bit 31.
- R6: After releasing an entry, the engine fetches the next index without waiting for a poll. After entry 2^L - 1 it wraps to entry 0, where L is register 2 bits 3:0, clamped to 9. With L = 0 the ring has one entry.
- R7: When done_count is 0, err is high for exactly the cycle of the status write, and the entry is still released.
- R8: Register port: reg_addr 0 loads base bits 15:0, reg_addr 1 loads base bits 31:16, and reg_addr 2 loads L. Any of these writes sets the index to 0, and the write wins over an advance in the same cycle. A descriptor already in progress finishes at the address it was fetched from, and the next fetch uses the new base at index 0.
- R9: A done pulse while no buffer is in service causes no write and no other effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select: 0 base low, 1 base high, 2 log2 length |
| reg_wdata | input | 16 | Register write data |
| poll | input | 1 | Demand pulse that re-reads a stalled entry |
| mem_req | output | 1 | Memory cycle request |
| mem_we | output | 1 | Memory write enable (0 = read) |
| mem_addr | output | 32 | Byte address of the word |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid the cycle after a read request |
| buf_valid | output | 1 | Buffer offer valid |
| buf_ready | input | 1 | Consumer accepts the offer |
| buf_addr | output | 32 | Offered buffer address |
| buf_len | output | 16 | Offered byte count |
| done | input | 1 | Consumer completion pulse |
| done_count | input | 16 | Bytes the consumer handled |
| done_stat | input | 16 | Completion status flags |
| err | output | 1 | Zero byte count reported, high during the status write |

## Verification
Two functions can land in the same cycle: a register write rewinds the index to 0 while the ownership-release write advances it. The bench watches for the release write to offset 4 and drives a length write on that same cycle. The check passes only if the next fetch goes to entry 0 rather than entry 1, and only if entry 1 keeps its ownership flag. A second case changes the base while an offer is outstanding. The old descriptor must still receive both of its writes at the old address, and the first fetch afterwards must land at the new base.

// File: rtl/ring_own_engine.sv
module ring_own_engine #(
  parameter int POLL_CYCLES = 1024,
  parameter int MAX_LOG2 = 9,
  localparam int IW = MAX_LOG2,
  localparam int TW = $clog2(POLL_CYCLES + 1)
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_we,
  input  logic [1:0]  reg_addr,
  input  logic [15:0] reg_wdata,
  input  logic        poll,
  output logic        mem_req,
  output logic        mem_we,
  output logic [31:0] mem_addr,
  output logic [31:0] mem_wdata,
  input  logic [31:0] mem_rdata,
  output logic        buf_valid,
  input  logic        buf_ready,
  output logic [31:0] buf_addr,
  output logic [15:0] buf_len,
  input  logic        done,
  input  logic [15:0] done_count,
  input  logic [15:0] done_stat,
  output logic        err
);

  typedef enum logic [3:0] {
    S_WAIT, S_RD1, S_CHK, S_RD0, S_CAP0, S_OFFER, S_BUSY, S_WST, S_WOWN
  } st_t;

  st_t           st;
  logic [31:0]   base_q;
  logic [3:0]    lg_q;
  logic [IW-1:0] idx_q;
  logic          rst_pend;
  logic [TW-1:0] tmr;
  logic [31:0]   desc_q;
  logic [31:0]   w0_q;
  logic [30:0]   w1_q;
  logic [31:0]   stat_q;
  logic          zero_q;

  logic [3:0]    lg_eff;
  logic [IW-1:0] mask;
  logic [IW-1:0] idx_next;
  logic [31:0]   cur_addr;
  logic          reg_hit;
  logic          wake;

  assign lg_eff   = (lg_q > 4'(MAX_LOG2)) ? 4'(MAX_LOG2) : lg_q;
  assign mask     = IW'((32'd1 << lg_eff) - 32'd1);
  assign idx_next = (idx_q + 1'b1) & mask;
  assign cur_addr = base_q + 32'({idx_q, 4'b0000});
  assign reg_hit  = reg_we && (reg_addr != 2'd3);
  assign wake     = poll || (tmr == TW'(POLL_CYCLES - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_q <= '0;
      lg_q   <= '0;
    end else if (reg_we) begin
      case (reg_addr)
        2'd0: base_q[15:0]  <= reg_wdata;
        2'd1: base_q[31:16] <= reg_wdata;
        2'd2: lg_q          <= reg_wdata[3:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx_q    <= '0;
      rst_pend <= 1'b0;
    end else begin
      if (reg_hit) idx_q <= '0;
      else if (st == S_WOWN && !rst_pend) idx_q <= idx_next;
      if (reg_hit) rst_pend <= 1'b1;
      else if (st == S_RD1 || st == S_WOWN) rst_pend <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || st != S_WAIT) tmr <= '0;
    else if (!wake) tmr <= tmr + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= S_WAIT;
      desc_q <= '0;
      w0_q   <= '0;
      w1_q   <= '0;
      stat_q <= '0;
      zero_q <= 1'b0;
    end else begin
      case (st)
        S_WAIT: if (wake) st <= S_RD1;
        S_RD1: begin
          desc_q <= cur_addr;
          st     <= S_CHK;
        end
        S_CHK: begin
          if (mem_rdata[31]) begin
            w1_q <= mem_rdata[30:0];
            st   <= S_RD0;
          end else begin
            st <= S_WAIT;
          end
        end
        S_RD0: st <= S_CAP0;
        S_CAP0: begin
          w0_q <= mem_rdata;
          st   <= S_OFFER;
        end
        S_OFFER: if (buf_ready) st <= S_BUSY;
        S_BUSY: begin
          if (done) begin
            stat_q <= {done_stat, done_count};
            zero_q <= (done_count == 16'd0);
            st     <= S_WST;
          end
        end
        S_WST:  st <= S_WOWN;
        S_WOWN: st <= S_RD1;
        default: st <= S_WAIT;
      endcase
    end
  end

  assign mem_req   = (st == S_RD1) || (st == S_RD0) || (st == S_WST) || (st == S_WOWN);
  assign mem_we    = (st == S_WST) || (st == S_WOWN);
  assign mem_wdata = (st == S_WST) ? stat_q : {1'b0, w1_q};
  always_comb begin
    case (st)
      S_RD1:   mem_addr = cur_addr + 32'd4;
      S_WST:   mem_addr = desc_q + 32'd8;
      S_WOWN:  mem_addr = desc_q + 32'd4;
      default: mem_addr = desc_q;
    endcase
  end

  assign buf_valid = (st == S_OFFER);
  assign buf_addr  = w0_q;
  assign buf_len   = w1_q[15:0];
  assign err       = (st == S_WST) && zero_q;

  p_never_grant_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we && mem_addr[3:0] == 4'h4) |-> !mem_wdata[31]);

  p_status_first_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we && mem_addr[3:0] == 4'h4) |->
      $past(mem_req && mem_we && mem_addr[3:0] == 4'h8));

  p_offer_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (buf_valid && !buf_ready) |=> (buf_valid && $stable(buf_addr) && $stable(buf_len)));

  p_err_on_status_r7: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> (mem_req && mem_we && mem_addr[3:0] == 4'h8 && mem_wdata[15:0] == 16'h0));

  p_idx_in_ring_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (idx_q & ~mask) == '0);

  p_stall_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_CHK && !mem_rdata[31]) |=> !mem_req);

endmodule

// File: tb/sim_ring_own_engine.sv
module sim_ring_own_engine;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_we = 1'b0;
  logic [1:0] reg_addr = '0;
  logic [15:0] reg_wdata = '0;
  logic poll = 1'b0;
  logic mem_req, mem_we;
  logic [31:0] mem_addr, mem_wdata;
  logic [31:0] mem_rdata = '0;
  logic buf_valid;
  logic buf_ready = 1'b0;
  logic [31:0] buf_addr;
  logic [15:0] buf_len;
  logic done, done_c = 1'b0, done_x = 1'b0;
  logic [15:0] done_count = '0, done_stat = '0;
  logic err;

  assign done = done_c | done_x;
  always #2 clk = ~clk;

  ring_own_engine #(.POLL_CYCLES(64)) u0 (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .poll(poll), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .buf_valid(buf_valid),
    .buf_ready(buf_ready), .buf_addr(buf_addr), .buf_len(buf_len), .done(done),
    .done_count(done_count), .done_stat(done_stat), .err(err));

  logic [31:0] mem [0:1023];
  always @(posedge clk) begin
    if (mem_req) begin
      if (mem_we) mem[mem_addr[11:2]] <= mem_wdata;
      else mem_rdata <= mem[mem_addr[11:2]];
    end
  end

  int checks = 0, fails = 0, wr_cnt = 0;
  bit finished = 0, prev_status = 0;
  logic [31:0] exp_wa[$], exp_wd[$], exp_oa[$], rd_log[$];
  logic [15:0] exp_ol[$];
  localparam logic [31:0] B1 = 32'h0003_0100;
  localparam logic [31:0] B2 = 32'h0003_0200;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic int widx(input logic [31:0] b, input int i, input int k);
    return (int'(b[11:0]) + 16 * i + 4 * k) >> 2;
  endfunction

  task automatic set_desc(input logic [31:0] b, input int i, input logic [31:0] a,
                          input logic [15:0] len, input bit own);
    mem[widx(b, i, 0)] = a;
    mem[widx(b, i, 1)] = {own, 15'h2A5A, len};
    mem[widx(b, i, 2)] = 32'hDEAD_0000;
  endtask

  task automatic expect_desc(input logic [31:0] b, input int i);
    logic [31:0] w0, w1;
    w0 = mem[widx(b, i, 0)];
    w1 = mem[widx(b, i, 1)];
    exp_oa.push_back(w0);
    exp_ol.push_back(w1[15:0]);
    exp_wa.push_back(b + 32'(16 * i) + 32'd8);
    exp_wd.push_back({w0[15:0], w1[15:0]});
    exp_wa.push_back(b + 32'(16 * i) + 32'd4);
    exp_wd.push_back({1'b0, w1[30:0]});
  endtask

  task automatic reg_write(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic poll_pulse();
    @(negedge clk);
    poll = 1'b1;
    @(negedge clk);
    poll = 1'b0;
  endtask

  // Monitor: write scoreboard and read log
  always @(negedge clk) begin
    if (rst_n) begin
      if (mem_req && mem_we) begin
        wr_cnt++;
        if (exp_wa.size() == 0) begin
          chk(1'b0, "R5 unexpected write", mem_addr, 32'h0);
        end else begin
          logic [31:0] ea, ed;
          ea = exp_wa.pop_front();
          ed = exp_wd.pop_front();
          chk(mem_addr == ea, "R5 write address", mem_addr, ea);
          chk(mem_wdata == ed, "R5 write data", mem_wdata, ed);
          if (ea[3:0] == 4'h8)
            chk(err == (ed[15:0] == 16'h0), "R7 err at status write", 32'(err), 32'(ed[15:0] == 16'h0));
          if (ea[3:0] == 4'h4)
            chk(prev_status, "R5 status precedes release", 32'(prev_status), 32'h1);
        end
        prev_status = (mem_addr[3:0] == 4'h8);
      end else begin
        prev_status = 1'b0;
        if (err) chk(1'b0, "R7 err outside status write", 32'h1, 32'h0);
        if (mem_req) rd_log.push_back(mem_addr);
      end
    end
  end

  // Consumer: checks offers, then reports completion
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && buf_valid) begin
        logic [31:0] a;
        logic [15:0] l;
        a = buf_addr; l = buf_len;
        if (exp_oa.size() == 0) begin
          chk(1'b0, "R3 unexpected offer", a, 32'h0);
        end else begin
          logic [31:0] ea;
          logic [15:0] el;
          ea = exp_oa.pop_front();
          el = exp_ol.pop_front();
          chk(a == ea, "R4 offer address", a, ea);
          chk(l == el, "R4 offer length", 32'(l), 32'(el));
        end
        @(negedge clk);
        chk(buf_valid && buf_addr == a && buf_len == l, "R4 offer held", buf_addr, a);
        buf_ready = 1'b1;
        @(negedge clk);
        buf_ready = 1'b0;
        chk(!buf_valid, "R4 offer dropped after accept", 32'(buf_valid), 32'h0);
        repeat (3) @(negedge clk);
        done_count = l; done_stat = a[15:0]; done_c = 1'b1;
        @(negedge clk);
        done_c = 1'b0;
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; fails++;
      $display("FAIL watchdog expired actual=%h expected=%h", 32'h0, 32'h1);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    int j;
    bit ok;
    int w0;
    for (int i = 0; i < 1024; i++) mem[i] = 32'h0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!mem_req && !buf_valid && !err, "R1 reset state", {mem_req, buf_valid, err}, 32'h0);
    repeat (10) @(negedge clk);
    chk(rd_log.size() == 0, "R1 quiet after reset", rd_log.size(), 32'h0);

    set_desc(B1, 0, 32'h1000_0040, 16'd64, 1'b1);
    set_desc(B1, 1, 32'h2000_0080, 16'd128, 1'b1);
    set_desc(B1, 2, 32'h3000_00C0, 16'd0, 1'b1);
    set_desc(B1, 3, 32'h4000_0100, 16'd1500, 1'b1);
    reg_write(2'd0, 16'h0100);
    reg_write(2'd1, 16'h0003);
    reg_write(2'd2, 16'd2);
    for (int i = 0; i < 4; i++) expect_desc(B1, i);
    rd_log.delete();
    poll_pulse();
    repeat (120) @(negedge clk);
    chk(rd_log.size() > 0 && rd_log[0] == B1 + 32'd4, "R2 poll fetch address",
        rd_log.size() > 0 ? rd_log[0] : 32'h0, B1 + 32'd4);
    chk(exp_wa.size() == 0, "R5 all writes seen", exp_wa.size(), 32'h0);
    chk(exp_oa.size() == 0, "R4 all offers seen", exp_oa.size(), 32'h0);
    chk(!mem[widx(B1, 2, 1)][31], "R7 zero-count entry released", mem[widx(B1, 2, 1)], 32'h0);
    j = -1;
    foreach (rd_log[k]) if (rd_log[k] == B1 + 32'h30 && j < 0) j = k;
    chk(j >= 0 && j + 1 < rd_log.size() && rd_log[j + 1] == B1 + 32'd4, "R6 wrap to entry 0",
        (j >= 0 && j + 1 < rd_log.size()) ? rd_log[j + 1] : 32'h0, B1 + 32'd4);

    // Stall at host-owned entry 0 with entry 1 owned
    set_desc(B1, 1, 32'h2100_0011, 16'd20, 1'b1);
    rd_log.delete();
    poll_pulse();
    repeat (20) @(negedge clk);
    ok = rd_log.size() >= 1;
    foreach (rd_log[k]) if (rd_log[k] != B1 + 32'd4) ok = 0;
    chk(ok, "R3 stall reads only own word of entry 0", rd_log.size() > 0 ? rd_log[0] : 32'h0, B1 + 32'd4);
    chk(mem[widx(B1, 1, 1)][31], "R3 later entry untouched", mem[widx(B1, 1, 1)], 32'h8000_0000);
    rd_log.delete();
    repeat (70) @(negedge clk);
    chk(rd_log.size() >= 1 && rd_log[0] == B1 + 32'd4, "R2 timer re-read",
        rd_log.size() > 0 ? rd_log[0] : 32'h0, B1 + 32'd4);
    set_desc(B1, 0, 32'h5000_0022, 16'd16, 1'b1);
    expect_desc(B1, 0);
    expect_desc(B1, 1);
    repeat (110) @(negedge clk);
    chk(exp_wa.size() == 0 && exp_oa.size() == 0, "R2 timer resumes in order", exp_wa.size(), 32'h0);

    // Stray done while idle
    w0 = wr_cnt;
    @(negedge clk);
    done_x = 1'b1; done_count = 16'd5; done_stat = 16'h1;
    @(negedge clk);
    done_x = 1'b0;
    repeat (8) @(negedge clk);
    chk(wr_cnt == w0 && !buf_valid, "R9 stray done ignored", wr_cnt, w0);

    // Length write rewinds index, ring of one entry
    reg_write(2'd2, 16'd0);
    set_desc(B1, 0, 32'h6000_0033, 16'd8, 1'b1);
    expect_desc(B1, 0);
    rd_log.delete();
    poll_pulse();
    repeat (40) @(negedge clk);
    ok = rd_log.size() >= 3;
    foreach (rd_log[k]) if (rd_log[k] != B1 + 32'd4 && rd_log[k] != B1) ok = 0;
    chk(ok && exp_wa.size() == 0, "R6 one-entry ring stays at entry 0",
        rd_log.size() > 0 ? rd_log[rd_log.size() - 1] : 32'h0, B1 + 32'd4);
    chk(rd_log.size() > 0 && rd_log[0] == B1 + 32'd4, "R8 register write rewinds index",
        rd_log.size() > 0 ? rd_log[0] : 32'h0, B1 + 32'd4);

    // Collision: length write in the release cycle
    reg_write(2'd2, 16'd2);
    set_desc(B1, 0, 32'h7000_0044, 16'd32, 1'b1);
    set_desc(B1, 1, 32'h7100_0055, 16'd48, 1'b1);
    expect_desc(B1, 0);
    rd_log.delete();
    poll_pulse();
    for (int t = 0; t < 60; t++) begin
      @(negedge clk);
      if (mem_req && mem_we && mem_addr == B1 + 32'd4) break;
    end
    reg_we = 1'b1; reg_addr = 2'd2; reg_wdata = 16'd2;
    @(negedge clk);
    reg_we = 1'b0;
    repeat (20) @(negedge clk);
    j = -1;
    foreach (rd_log[k]) if (rd_log[k] == B1 && j < 0) j = k;
    chk(j >= 0 && j + 1 < rd_log.size() && rd_log[j + 1] == B1 + 32'd4, "R8 rewind beats advance",
        (j >= 0 && j + 1 < rd_log.size()) ? rd_log[j + 1] : 32'h0, B1 + 32'd4);
    chk(mem[widx(B1, 1, 1)][31] && exp_wa.size() == 0, "R8 entry 1 not processed",
        mem[widx(B1, 1, 1)], 32'h8000_0000);

    // Base change while an offer is outstanding
    set_desc(B1, 0, 32'h7200_0066, 16'd4, 1'b1);
    expect_desc(B1, 0);
    poll_pulse();
    for (int t = 0; t < 60; t++) begin
      @(negedge clk);
      if (buf_valid) break;
    end
    rd_log.delete();
    reg_we = 1'b1; reg_addr = 2'd0; reg_wdata = 16'h0200;
    @(negedge clk);
    reg_we = 1'b0;
    repeat (30) @(negedge clk);
    chk(exp_wa.size() == 0, "R8 in-flight entry finishes at old address", exp_wa.size(), 32'h0);
    chk(rd_log.size() > 0 && rd_log[0] == B2 + 32'd4, "R8 next fetch at new base",
        rd_log.size() > 0 ? rd_log[0] : 32'h0, B2 + 32'd4);

    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule